// File: doc/BRIEF.md
# Miscellaneous Interrupt Aggregator

This block gathers up to 32 level-type peripheral interrupt lines into one interrupt request for a host processor. Each source has one bit in a latched pending register and one bit in a mask register. The request output is high whenever at least one pending bit is also unmasked.

Software reaches the two registers over a small word-indexed bus with separate read and write strobes.

- **Masking.** Software masks or unmasks a source by writing the whole mask word.
- **Acknowledging.** Software acknowledges a source by writing the pending register with that source's bit at zero and every other bit at one. This is a read-modify-write that clears only the source being serviced.
- **Service order.** A third, read-only register gives the index of the lowest-numbered source that is pending and unmasked, together with a valid flag. This supports a lowest-bit-first service loop.
- **Reserved source.** Source 5 is reserved for the processor performance-counter interrupt. Its pending-and-unmasked state is also brought out on a dedicated pin.

Top module: `misc_irq_aggregator`

## Requirements
- R1: After reset the pending register, the mask register and the read data are all zero, and `irq_o` and `perf_irq_o` are low.
- R2: A source input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the source goes low, until software clears it.
- R3: A write to word index 0 (byte offset 0x0) clears every pending bit whose write-data bit is 0. A write-data bit of 1 leaves its pending bit unchanged and never sets it.
- R4: If a source is high in the same cycle that a write clears its pending bit, the bit stays set.
- R5: A write to word index 1 (byte offset 0x4) stores all 32 bits of write data into the mask register. A 1 unmasks a source and a 0 masks it.
- R6: `irq_o` is high exactly when the bitwise AND of the pending and mask registers is nonzero.
- R7: A read strobe loads `bus_rdata` at the next clock edge with the addressed register. A read issued in the cycle after a write returns the newly written value.
- R8: Word index 2 (byte offset 0x8) reads as follows. Bit 31 is a valid flag. Bits 4:0 hold the index of the lowest-numbered source that is both pending and unmasked. All other bits are 0, and the whole word is 0 when no source is pending and unmasked.
- R9: `perf_irq_o` is high exactly when source 5 is pending and unmasked.
- R10: Writes to word index 2 or 3 change no register, and reads of word index 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Level interrupt sources, one per bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index: 0 pending, 1 mask, 2 lowest-pending index, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the edge after the read strobe |
| irq_o | output | 1 | Aggregated interrupt request |
| perf_irq_o | output | 1 | Performance-counter source pending and unmasked |

## Verification
The assertions assume that the source vector, the strobes, the address and the write data are steady around each rising edge. They also assume that reads and writes are never issued in the same cycle, so a read-back property can compare against the register contents of the previous cycle.

The bench drives every input on the falling edge and issues each bus access as a single-strobe cycle. It raises sources either as one-cycle pulses or as held levels, so the latching and same-cycle-clear behaviour of the pending register can be seen through register reads and the request pins.

// File: rtl/misc_irq_pkg.sv
// Package: shared sizes and register word indices for the interrupt aggregator.
// Assumes a 32-bit register bus and at most 32 sources.
package misc_irq_pkg;
    localparam int NUM_SRC  = 32;
    localparam int DATA_W   = 32;
    localparam int REG_AW   = 2;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int PERF_SRC = 5;

    typedef enum logic [REG_AW-1:0] {
        REG_PEND  = 2'd0,
        REG_MASK  = 2'd1,
        REG_FIRST = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_pending_reg.sv
// Module: latched pending register. A high source sets its bit. A write
// clears the bits whose write-data bit is zero. A source set wins over a clear
// in the same cycle. Assumes sources are synchronous to clk.
module irq_pending_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] keep_mask,
    output logic [WIDTH-1:0] pend_q
);
    logic [WIDTH-1:0] kept;

    // Bits that survive a software clear this cycle.
    always_comb begin
        kept = clr_we ? (pend_q & keep_mask) : pend_q;
    end

    // Register the surviving bits plus any newly asserted sources.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= kept | src;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: full-word mask register, loaded only by whole-word writes.
// Assumes the write strobe is qualified by address outside.
module irq_mask_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);
    // Load the whole word on a write, and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= '0;
        else if (we) mask_q <= wdata;
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Module: finds the lowest-numbered set bit of a vector.
// The output is combinational. The index is zero when valid is low.
module irq_lowest_pick #(
    parameter int WIDTH = 32,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             valid,
    output logic [IW-1:0]    idx
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx   = '0;
        valid = |vec;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end
endmodule

// File: rtl/misc_irq_aggregator.sv
// Module: top of the interrupt aggregator. It holds the pending and mask
// registers, drives the aggregated request and the performance-counter
// request, and serves registered reads. Assumes a read and a write are not
// issued in the same cycle.
module misc_irq_aggregator
    import misc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              perf_irq_o
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] active;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic               pend_we;
    logic               mask_we;
    logic [DATA_W-1:0]  rd_mux;

    // Qualify the write strobe by word index.
    always_comb begin
        pend_we = bus_wr && (bus_addr == REG_PEND);
        mask_we = bus_wr && (bus_addr == REG_MASK);
    end

    irq_pending_reg #(.WIDTH(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_i),
        .clr_we    (pend_we),
        .keep_mask (bus_wdata[NUM_SRC-1:0]),
        .pend_q    (pend_q)
    );

    irq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (bus_wdata[NUM_SRC-1:0]),
        .mask_q(mask_q)
    );

    // Sources that are both pending and unmasked.
    always_comb begin
        active = pend_q & mask_q;
    end

    irq_lowest_pick #(.WIDTH(NUM_SRC)) u_pick (
        .vec  (active),
        .valid(pick_valid),
        .idx  (pick_idx)
    );

    // Drive the request outputs from the pick result and the reserved source.
    always_comb begin
        irq_o      = pick_valid;
        perf_irq_o = active[PERF_SRC];
    end

    // Select the register addressed by the read.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            REG_PEND:  rd_mux[NUM_SRC-1:0] = pend_q;
            REG_MASK:  rd_mux[NUM_SRC-1:0] = mask_q;
            REG_FIRST: begin
                rd_mux[DATA_W-1]  = pick_valid;
                rd_mux[IDX_W-1:0] = pick_idx;
            end
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/misc_irq_checker.sv
// Module: assertion checker bound to misc_irq_aggregator.
module misc_irq_checker
    import misc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               irq_o,
    input  logic               perf_irq_o,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] mask_q
);
    // R2
    src_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

    // R3
    clear_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_PEND && src_i == '0)
        |=> (pend_q == ($past(pend_q) & $past(bus_wdata[NUM_SRC-1:0]))));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_MASK) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

    // R7
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == REG_PEND)
        |=> (bus_rdata[NUM_SRC-1:0] == $past(pend_q)));

    // R9
    perf_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perf_irq_o |-> irq_o);

    // R10
    no_write_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1] && src_i == '0)
        |=> ($stable(mask_q) && $stable(pend_q)));
endmodule

bind misc_irq_aggregator misc_irq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .perf_irq_o (perf_irq_o),
    .pend_q     (pend_q),
    .mask_q     (mask_q)
);

// File: tb/sim_misc_irq_aggregator.sv
// Bench: directed scenarios for misc_irq_aggregator, one task per scenario.
module sim_misc_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        perf_irq_o;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    misc_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .perf_irq_o(perf_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk);
        src_i = s;
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 perf", {31'b0, perf_irq_o}, 32'h0);
        rd(2'd0, d); check("R1 pending", d, 32'h0);
        rd(2'd1, d); check("R1 mask", d, 32'h0);
    endtask

    task automatic t_latch_and_mask();
        logic [31:0] d;
        pulse(32'h0000_0008);
        rd(2'd0, d); check("R2 latched", d, 32'h0000_0008);
        check("R6 masked no irq", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h0000_0008);
        check("R6 irq on unmask", {31'b0, irq_o}, 32'h1);
        rd(2'd1, d); check("R7 R5 mask readback", d, 32'h0000_0008);
        wr(2'd1, 32'hA5C3_0F18);
        rd(2'd1, d); check("R5 full word", d, 32'hA5C3_0F18);
        wr(2'd1, 32'h0);
        check("R6 irq off on mask", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFF7);
        rd(2'd0, d); check("R3 clear one", d, 32'h0);
        pulse(32'h0000_020A);
        wr(2'd0, ~32'h0000_0008);
        rd(2'd0, d); check("R3 ones keep", d, 32'h0000_0202);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R3 clear all", d, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk); src_i = 32'h0000_0200;
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R4 set wins", d, 32'h0000_0200);
        src_i = '0;
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R4 clear after release", d, 32'h0);
    endtask

    task automatic t_first();
        logic [31:0] d;
        pulse(32'h0010_1080);
        wr(2'd1, 32'h0010_1000);
        rd(2'd2, d); check("R8 lowest 12", d, 32'h8000_000C);
        wr(2'd1, 32'h0010_0000);
        rd(2'd2, d); check("R8 lowest 20", d, 32'h8000_0014);
        wr(2'd1, 32'h0);
        rd(2'd2, d); check("R8 none", d, 32'h0);
        pulse(32'h8000_0001);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R8 bit 0", d, 32'h8000_0000);
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd2, d); check("R8 next 7", d, 32'h8000_0007);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_perf();
        pulse(32'h0000_0020);
        wr(2'd1, 32'hFFFF_FFDF);
        check("R9 perf masked", {31'b0, perf_irq_o}, 32'h0);
        wr(2'd1, 32'h0000_0020);
        check("R9 perf high", {31'b0, perf_irq_o}, 32'h1);
        check("R9 irq high", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h0);
        check("R9 perf cleared", {31'b0, perf_irq_o}, 32'h0);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(2'd1, 32'h0000_00F0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h1234_5678);
        rd(2'd1, d); check("R10 mask kept", d, 32'h0000_00F0);
        rd(2'd0, d); check("R10 pending kept", d, 32'h0);
        rd(2'd3, d); check("R10 idx3 zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_and_mask();
        t_clear();
        t_same_cycle();
        t_first();
        t_perf();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule